// File: doc/BRIEF.md
# Suspend Request and Acknowledge Controller

This block decides when a processor core may drop into its low-power suspend state and when it comes back out. A suspend can start from an active-low request pin driven by the system, or from the core executing a halt. Before it acknowledges, the controller waits for the core to report that it is idle. Idle means no instruction is running, no decoded instruction is queued and no bus cycle is outstanding. Once the core is idle, the controller drives the active-low acknowledge and shuts the clock gates.

A configuration bit gates the whole mechanism. While that bit is clear, which is its state after reset, requests and halts start nothing and the acknowledge pin is not driven. A second configuration input picks what suspend stops. In one setting only the core clock is gated. In the other, the system clock is gated as well, and the block raises a flag telling the board it is safe to stop the external clock. The block leaves suspend when the request is released (request-started suspend) or when a wake interrupt arrives (halt-started suspend). It turns the clocks back on one cycle before it withdraws the acknowledge.

Top module: `susp_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, susp_ack_n is 1, susp_ack_oe is 0, core_clk_en and sys_clk_en are 1, and sysclk_stop_ok is 0.
- R2: While susp_en is 0, a low susp_req_n or a halt pulse leaves susp_ack_n at 1 and both clock enables at 1.
- R3: susp_ack_oe equals susp_en in every cycle.
- R4: susp_req_n passes through a two-stage synchroniser. With susp_en=1 and core_idle=1, a request driven low just after edge 0 moves the block to the draining state at edge 3, and susp_ack_n falls at edge 4.
- R5: While draining, susp_ack_n stays 1 and the clock enables stay 1 for as long as core_idle is 0. susp_ack_n falls at the first edge that samples core_idle=1.
- R6: With susp_en=1, a one-cycle halt pulse sampled at edge 0 starts draining at edge 0. With core_idle=1, susp_ack_n falls at edge 1.
- R7: When all_clk_mode was 0 at suspend entry, the suspended state has core_clk_en=0, sys_clk_en=1 and sysclk_stop_ok=0.
- R8: When all_clk_mode was 1 at suspend entry, the suspended state has core_clk_en=0, sys_clk_en=0 and sysclk_stop_ok=1. sysclk_stop_ok is 1 only while susp_ack_n is 0.
- R9: In a request-started suspend, releasing susp_req_n just after edge 0 sets core_clk_en and sys_clk_en to 1 at edge 3 while susp_ack_n is still 0. susp_ack_n returns to 1 at edge 4.
- R10: In a halt-started suspend, wake_irq sampled at edge 0 restores the clocks at edge 0 with susp_ack_n still 0. susp_ack_n returns to 1 at edge 1.
- R11: A request-started drain is cancelled and the block returns to run if susp_en is cleared or the synchronised request is released before the core is idle. A later core_idle=1 then produces no acknowledge.
- R12: all_clk_mode is captured at suspend entry. Changing it while suspended does not change the clock enables or sysclk_stop_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| susp_req_n | input | 1 | Asynchronous active-low suspend request |
| halt | input | 1 | One-cycle pulse: core executed a halt |
| core_idle | input | 1 | Core has no instruction, queued decode or bus cycle in flight |
| wake_irq | input | 1 | Interrupt that ends a halt-started suspend |
| susp_en | input | 1 | Configuration enable for the suspend mechanism |
| all_clk_mode | input | 1 | 0: gate core clock only; 1: gate core and system clocks |
| susp_ack_n | output | 1 | Active-low suspend acknowledge value |
| susp_ack_oe | output | 1 | Output enable for the acknowledge pin driver |
| core_clk_en | output | 1 | Core clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| sysclk_stop_ok | output | 1 | External system clock may be stopped |

## Verification
The hardest case to reach from the ports is a cancelled drain. The block has to be in the draining state, with the request or the enable withdrawn, before the core ever reports idle, and that window only exists when core_idle is held low. The bench holds core_idle at 0, asserts the request, counts the synchroniser stages and the state register, then clears the enable or releases the pin. Only after that does it raise core_idle, and it checks that the acknowledge and the clock enables never move.

// File: rtl/susp_pkg.sv
`timescale 1ns/1ps
package susp_pkg;

    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_SUSP   = 2'd2,
        ST_RESUME = 2'd3
    } susp_state_e;

    typedef enum logic {
        SRC_REQ  = 1'b0,
        SRC_HALT = 1'b1
    } susp_src_e;

    typedef struct packed {
        logic core_en;
        logic sys_en;
        logic stop_ok;
    } gate_t;

    // Acknowledge is held from suspend entry until the resume cycle ends.
    function automatic logic ack_active(input susp_state_e st);
        return (st == ST_SUSP) || (st == ST_RESUME);
    endfunction

    // Gate pattern for a state and a captured clock-stop mode.
    function automatic gate_t gates_for(input susp_state_e st, input logic all_mode);
        gate_t g;
        g.core_en = 1'b1;
        g.sys_en  = 1'b1;
        g.stop_ok = 1'b0;
        if (st == ST_SUSP) begin
            g.core_en = 1'b0;
            g.sys_en  = !all_mode;
            g.stop_ok = all_mode;
        end
        return g;
    endfunction

endpackage

// File: rtl/susp_sync.sv
`timescale 1ns/1ps
module susp_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= IDLE_LVL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= IDLE_LVL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/susp_fsm.sv
`timescale 1ns/1ps
module susp_fsm
    import susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_act,
    input  logic        halt,
    input  logic        core_idle,
    input  logic        wake_irq,
    input  logic        en,
    output susp_state_e state,
    output logic        enter_susp
);
    susp_state_e state_nx;
    susp_src_e   src_q, src_nx;

    always_comb begin
        state_nx   = state;
        src_nx     = src_q;
        enter_susp = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (en && req_act) begin
                    state_nx = ST_DRAIN;
                    src_nx   = SRC_REQ;
                end else if (en && halt) begin
                    state_nx = ST_DRAIN;
                    src_nx   = SRC_HALT;
                end
            end
            ST_DRAIN: begin
                if (!en) begin
                    state_nx = ST_RUN;
                end else if (src_q == SRC_REQ && !req_act) begin
                    state_nx = ST_RUN;
                end else if (core_idle) begin
                    state_nx   = ST_SUSP;
                    enter_susp = 1'b1;
                end
            end
            ST_SUSP: begin
                if (src_q == SRC_REQ && !req_act)
                    state_nx = ST_RESUME;
                else if (src_q == SRC_HALT && wake_irq)
                    state_nx = ST_RESUME;
            end
            ST_RESUME: state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            src_q <= SRC_REQ;
        end else begin
            state <= state_nx;
            src_q <= src_nx;
        end
    end
endmodule

// File: rtl/susp_clkgate.sv
`timescale 1ns/1ps
module susp_clkgate
    import susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  susp_state_e state,
    input  logic        enter_susp,
    input  logic        all_clk_mode,
    output gate_t       gates
);
    logic mode_q;

    // Mode is frozen on the suspend entry edge only.
    always_ff @(posedge clk) begin
        if (rst)             mode_q <= 1'b0;
        else if (enter_susp) mode_q <= all_clk_mode;
    end

    assign gates = gates_for(state, mode_q);
endmodule

// File: rtl/susp_ctrl.sv
`timescale 1ns/1ps
module susp_ctrl
    import susp_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic susp_req_n,
    input  logic halt,
    input  logic core_idle,
    input  logic wake_irq,
    input  logic susp_en,
    input  logic all_clk_mode,
    output logic susp_ack_n,
    output logic susp_ack_oe,
    output logic core_clk_en,
    output logic sys_clk_en,
    output logic sysclk_stop_ok
);
    logic        req_n_sync;
    logic        req_act;
    susp_state_e state;
    logic        enter_susp;
    gate_t       gates;

    susp_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (susp_req_n),
        .q_sync  (req_n_sync)
    );

    assign req_act = !req_n_sync;

    susp_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_act    (req_act),
        .halt       (halt),
        .core_idle  (core_idle),
        .wake_irq   (wake_irq),
        .en         (susp_en),
        .state      (state),
        .enter_susp (enter_susp)
    );

    susp_clkgate u_gate (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .enter_susp   (enter_susp),
        .all_clk_mode (all_clk_mode),
        .gates        (gates)
    );

    assign susp_ack_n     = !ack_active(state);
    assign susp_ack_oe    = susp_en;
    assign core_clk_en    = gates.core_en;
    assign sys_clk_en     = gates.sys_en;
    assign sysclk_stop_ok = gates.stop_ok;
endmodule

// File: rtl/susp_ctrl_chk.sv
`timescale 1ns/1ps
module susp_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic susp_en,
    input logic core_idle,
    input logic susp_ack_n,
    input logic core_clk_en,
    input logic sys_clk_en,
    input logic sysclk_stop_ok
);
    AST_DISABLED_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (!susp_en && susp_ack_n) |=> susp_ack_n); // R2

    AST_ACK_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_ack_n) |-> $past(core_idle)); // R5

    AST_CORE_GATE_ACKED: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en |-> !susp_ack_n); // R7

    AST_STOP_OK_SAFE: assert property (@(posedge clk) disable iff (rst)
        sysclk_stop_ok |-> (!susp_ack_n && !sys_clk_en && !core_clk_en)); // R8

    AST_CLK_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_ack_n) |-> (core_clk_en && $past(core_clk_en) && sys_clk_en)); // R9
endmodule

bind susp_ctrl susp_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .susp_en        (susp_en),
    .core_idle      (core_idle),
    .susp_ack_n     (susp_ack_n),
    .core_clk_en    (core_clk_en),
    .sys_clk_en     (sys_clk_en),
    .sysclk_stop_ok (sysclk_stop_ok)
);

// File: tb/tb_susp_ctrl.sv
`timescale 1ns/1ps
module tb_susp_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic susp_req_n = 1'b1;
    logic halt = 1'b0;
    logic core_idle = 1'b1;
    logic wake_irq = 1'b0;
    logic susp_en = 1'b0;
    logic all_clk_mode = 1'b0;
    logic susp_ack_n, susp_ack_oe, core_clk_en, sys_clk_en, sysclk_stop_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    susp_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .susp_req_n     (susp_req_n),
        .halt           (halt),
        .core_idle      (core_idle),
        .wake_irq       (wake_irq),
        .susp_en        (susp_en),
        .all_clk_mode   (all_clk_mode),
        .susp_ack_n     (susp_ack_n),
        .susp_ack_oe    (susp_ack_oe),
        .core_clk_en    (core_clk_en),
        .sys_clk_en     (sys_clk_en),
        .sysclk_stop_ok (sysclk_stop_ok)
    );

    // Advance n rising edges, then settle 2 ns past the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        step(1);
        chk("R1 ack_n in reset", susp_ack_n, 1'b1);
        chk("R1 oe in reset", susp_ack_oe, 1'b0);
        chk("R1 core_en in reset", core_clk_en, 1'b1);
        chk("R1 sys_en in reset", sys_clk_en, 1'b1);
        chk("R1 stop_ok in reset", sysclk_stop_ok, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1 ack_n after reset", susp_ack_n, 1'b1);
    endtask

    task automatic t_disabled();
        susp_en = 1'b0;
        susp_req_n = 1'b0;
        step(1);
        halt = 1'b1;
        step(1);
        halt = 1'b0;
        step(8);
        chk("R2 ack_n disabled", susp_ack_n, 1'b1);
        chk("R2 core_en disabled", core_clk_en, 1'b1);
        chk("R2 sys_en disabled", sys_clk_en, 1'b1);
        chk("R3 oe low while disabled", susp_ack_oe, 1'b0);
        susp_req_n = 1'b1;
        step(4);
    endtask

    task automatic t_req_core_mode();
        susp_en = 1'b1;
        #1;
        chk("R3 oe follows enable", susp_ack_oe, 1'b1);
        all_clk_mode = 1'b0;
        core_idle = 1'b1;
        susp_req_n = 1'b0;
        step(3);
        chk("R4 no ack while draining", susp_ack_n, 1'b1);
        step(1);
        chk("R4 ack after sync and drain", susp_ack_n, 1'b0);
        chk("R7 core gated", core_clk_en, 1'b0);
        chk("R7 sys running", sys_clk_en, 1'b1);
        chk("R7 no stop_ok", sysclk_stop_ok, 1'b0);
        all_clk_mode = 1'b1;
        step(2);
        chk("R12 sys_en unchanged", sys_clk_en, 1'b1);
        chk("R12 stop_ok unchanged", sysclk_stop_ok, 1'b0);
        all_clk_mode = 1'b0;
        susp_req_n = 1'b1;
        step(2);
        chk("R9 still suspended", core_clk_en, 1'b0);
        step(1);
        chk("R9 clocks back", core_clk_en, 1'b1);
        chk("R9 ack held in resume", susp_ack_n, 1'b0);
        step(1);
        chk("R9 ack released", susp_ack_n, 1'b1);
        step(2);
    endtask

    task automatic t_drain_all_mode();
        all_clk_mode = 1'b1;
        core_idle = 1'b0;
        susp_req_n = 1'b0;
        step(8);
        chk("R5 no ack while busy", susp_ack_n, 1'b1);
        chk("R5 core clock on while busy", core_clk_en, 1'b1);
        core_idle = 1'b1;
        step(1);
        chk("R5 ack after idle", susp_ack_n, 1'b0);
        chk("R8 core gated", core_clk_en, 1'b0);
        chk("R8 sys gated", sys_clk_en, 1'b0);
        chk("R8 stop_ok", sysclk_stop_ok, 1'b1);
        all_clk_mode = 1'b0;
        susp_req_n = 1'b1;
        step(3);
        chk("R8 stop_ok off in resume", sysclk_stop_ok, 1'b0);
        chk("R9 sys clock back", sys_clk_en, 1'b1);
        step(1);
        chk("R9 ack released all mode", susp_ack_n, 1'b1);
        step(2);
    endtask

    task automatic t_halt();
        all_clk_mode = 1'b0;
        core_idle = 1'b1;
        halt = 1'b1;
        step(1);
        halt = 1'b0;
        chk("R6 draining after halt", susp_ack_n, 1'b1);
        step(1);
        chk("R6 ack after halt", susp_ack_n, 1'b0);
        step(3);
        chk("R10 stays without wake", susp_ack_n, 1'b0);
        wake_irq = 1'b1;
        step(1);
        wake_irq = 1'b0;
        chk("R10 clocks back on wake", core_clk_en, 1'b1);
        chk("R10 ack held in resume", susp_ack_n, 1'b0);
        step(1);
        chk("R10 ack released", susp_ack_n, 1'b1);
        step(2);
    endtask

    task automatic t_cancel();
        core_idle = 1'b0;
        susp_req_n = 1'b0;
        step(3);
        susp_en = 1'b0;
        step(1);
        core_idle = 1'b1;
        step(3);
        chk("R11 enable cancel no ack", susp_ack_n, 1'b1);
        chk("R11 enable cancel clocks on", core_clk_en, 1'b1);
        susp_req_n = 1'b1;
        step(3);
        susp_en = 1'b1;
        core_idle = 1'b0;
        susp_req_n = 1'b0;
        step(3);
        susp_req_n = 1'b1;
        step(3);
        core_idle = 1'b1;
        step(3);
        chk("R11 release cancel no ack", susp_ack_n, 1'b1);
        chk("R11 release cancel clocks on", core_clk_en, 1'b1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_req_core_mode();
        t_drain_all_mode();
        t_halt();
        t_cancel();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule